// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a low-power SDRAM. It takes the memory from reset to a state where normal traffic can begin. From reset it holds the clock-enable and data-mask pins high and sends only no-operation commands. It does this for a parameterised settling interval, counted in clock cycles. It then sends the setup commands in this order:

- a precharge of every bank;
- two auto-refresh commands;
- a load of the mode register;
- a load of the extended mode register.

Each setup command is followed by its own minimum run of no-operation cycles. One cycle after the last gap ends, the block raises a done flag.

Four configuration inputs supply the mode register word: burst length, burst type, CAS latency and write-burst mode. The block checks them for reserved codes before it programs anything. If the combination is illegal, the sequence stops where the first register load would have gone. The block then raises an error flag, never raises done, and sends only no-operation commands until the next reset. The extended mode register value is a fixed parameter.

States, in order:

- `ST_PWR_WAIT`: settling interval.
- `ST_PRECHG`, then `ST_PRECHG_GAP`.
- `ST_REFR1`, then `ST_REFR1_GAP`.
- `ST_REFR2`, then `ST_REFR2_GAP`.
- `ST_LOAD_MR`, then `ST_MR_GAP`.
- `ST_LOAD_EMR`, then `ST_EMR_GAP`.
- `ST_READY` (terminal), or `ST_BAD_CFG` (terminal).

Transitions:

- A command state always moves on after a single cycle.
- A gap state, and the settling state, move on when the shared down-counter reaches zero.
- When `ST_REFR2_GAP` ends, the block goes to `ST_LOAD_MR` if the configuration is legal and to `ST_BAD_CFG` if it is not.

Top module: `sdram_boot_seq`

## Requirements
- R1: `mem_cke` and every bit of `mem_dqm` are 1 in every cycle, including during reset.
- R2: The command is the 4-bit code {cs_n, ras_n, cas_n, we_n}, with NOP = 0111. After reset is released, the first PWR_CYC cycles (counted by rising edges) carry NOP, with bank 0 and address 0.
- R3: In cycle PWR_CYC a precharge-all (0010) is issued with address bit 10 set, all other address bits zero and bank 0. PRE_CYC NOP cycles follow it.
- R4: Exactly two auto-refresh commands (0001) are issued, with address 0 and bank 0. Each is followed by RFC_CYC NOP cycles.
- R5: The mode register load (0000) is issued next, with bank 00. Its address word places burst length in bits 2:0, burst type in bit 3, CAS latency in bits 6:4 and write-burst mode in bit 9, with every other bit zero. MRD_CYC NOP cycles follow it.
- R6: A legal configuration has burst length code 000, 001, 010, 011, or 111 with burst type 0, and CAS latency code 010 or 011. Any write-burst value is allowed.
- R7: The extended mode register load (0000) follows the mode register gap. It uses bank 10 and address EMR_WORD, and MRD_CYC NOP cycles follow it.
- R8: `init_done` rises one cycle after the last gap and stays high, with NOP commands, until reset.
- R9: With an illegal configuration, no register load is issued. From the cycle where the mode register load would have gone, `cfg_err` is high, `init_done` stays low, and NOP is sent until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_blen | input | 3 | Burst length code |
| cfg_btype | input | 1 | Burst type (0 sequential, 1 interleaved) |
| cfg_cas | input | 3 | CAS latency code |
| cfg_wsingle | input | 1 | Write-burst mode (0 burst, 1 single) |
| mem_cke | output | 1 | Clock enable to memory |
| mem_dqm | output | DQM_W | Data mask to memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | 2 | Bank address |
| mem_addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Sequence complete |
| cfg_err | output | 1 | Configuration held a reserved code |

## Verification
The command pins are decoded from the state register alone, so a wrong state or transition shows on the pins in that same cycle. A counter that loads the wrong value or stops early moves every later command by whole cycles. The bench compares the pins against an expected schedule in every cycle, so a timing fault is caught at the first command it moves. A validation fault shows as a mode register load, or an error flag, in the wrong case, in the cycle where the load is due.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;

    typedef enum logic [3:0] {
        ST_PWR_WAIT,
        ST_PRECHG,
        ST_PRECHG_GAP,
        ST_REFR1,
        ST_REFR1_GAP,
        ST_REFR2,
        ST_REFR2_GAP,
        ST_LOAD_MR,
        ST_MR_GAP,
        ST_LOAD_EMR,
        ST_EMR_GAP,
        ST_READY,
        ST_BAD_CFG
    } boot_state_t;

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] CMD_NOP  = 4'b0111;
    localparam logic [3:0] CMD_PALL = 4'b0010;
    localparam logic [3:0] CMD_AREF = 4'b0001;
    localparam logic [3:0] CMD_LMR  = 4'b0000;

    localparam logic [1:0] BANK_MR  = 2'b00;
    localparam logic [1:0] BANK_EMR = 2'b10;

endpackage

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
    parameter int CNT_W    = 8,
    parameter int INIT_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= CNT_W'(INIT_VAL);
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdram_mode_fmt.sv
module sdram_mode_fmt #(
    parameter int ADDR_W = 13
) (
    input  logic [2:0]        blen,
    input  logic              btype,
    input  logic [2:0]        cas,
    input  logic              wsingle,
    output logic [ADDR_W-1:0] word,
    output logic              legal
);

    logic blen_ok;
    logic cas_ok;

    always_comb begin
        unique case (blen)
            3'b000, 3'b001, 3'b010, 3'b011: blen_ok = 1'b1;
            3'b111:                         blen_ok = !btype;
            default:                        blen_ok = 1'b0;
        endcase
        cas_ok = (cas == 3'b010) || (cas == 3'b011);
        legal  = blen_ok && cas_ok;
    end

    always_comb begin
        word      = '0;
        word[2:0] = blen;
        word[3]   = btype;
        word[6:4] = cas;
        word[9]   = wsingle;
    end

endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
    import sdram_boot_pkg::*;
#(
    parameter int             PWR_CYC  = 10000,
    parameter int             PRE_CYC  = 2,
    parameter int             RFC_CYC  = 6,
    parameter int             MRD_CYC  = 2,
    parameter int             ADDR_W   = 13,
    parameter int             DQM_W    = 2,
    parameter logic [12:0]    EMR_WORD = 13'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_blen,
    input  logic              cfg_btype,
    input  logic [2:0]        cfg_cas,
    input  logic              cfg_wsingle,
    output logic              mem_cke,
    output logic [DQM_W-1:0]  mem_dqm,
    output logic              mem_cs_n,
    output logic              mem_ras_n,
    output logic              mem_cas_n,
    output logic              mem_we_n,
    output logic [1:0]        mem_ba,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              init_done,
    output logic              cfg_err
);

    localparam int MAX_GAP = (PWR_CYC > RFC_CYC) ?
                             ((PWR_CYC > PRE_CYC) ? ((PWR_CYC > MRD_CYC) ? PWR_CYC : MRD_CYC)
                                                  : ((PRE_CYC > MRD_CYC) ? PRE_CYC : MRD_CYC)) :
                             ((RFC_CYC > PRE_CYC) ? ((RFC_CYC > MRD_CYC) ? RFC_CYC : MRD_CYC)
                                                  : ((PRE_CYC > MRD_CYC) ? PRE_CYC : MRD_CYC));
    localparam int CNT_W = $clog2(MAX_GAP + 1);
    localparam logic [CNT_W-1:0] PRE_LD = CNT_W'(PRE_CYC - 1);
    localparam logic [CNT_W-1:0] RFC_LD = CNT_W'(RFC_CYC - 1);
    localparam logic [CNT_W-1:0] MRD_LD = CNT_W'(MRD_CYC - 1);

    boot_state_t        state_q;
    logic               gap_over;
    logic               tmr_load;
    logic [CNT_W-1:0]   tmr_val;
    logic [ADDR_W-1:0]  mode_word;
    logic               mode_legal;
    logic [3:0]         cmd;

    sdram_gap_timer #(
        .CNT_W    (CNT_W),
        .INIT_VAL (PWR_CYC - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (gap_over)
    );

    sdram_mode_fmt #(
        .ADDR_W  (ADDR_W)
    ) u_fmt (
        .blen    (cfg_blen),
        .btype   (cfg_btype),
        .cas     (cfg_cas),
        .wsingle (cfg_wsingle),
        .word    (mode_word),
        .legal   (mode_legal)
    );

    // State register and transitions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PWR_WAIT;
        end else begin
            unique case (state_q)
                ST_PWR_WAIT:   if (gap_over) state_q <= ST_PRECHG;
                ST_PRECHG:     state_q <= ST_PRECHG_GAP;
                ST_PRECHG_GAP: if (gap_over) state_q <= ST_REFR1;
                ST_REFR1:      state_q <= ST_REFR1_GAP;
                ST_REFR1_GAP:  if (gap_over) state_q <= ST_REFR2;
                ST_REFR2:      state_q <= ST_REFR2_GAP;
                ST_REFR2_GAP:  if (gap_over) state_q <= mode_legal ? ST_LOAD_MR : ST_BAD_CFG;
                ST_LOAD_MR:    state_q <= ST_MR_GAP;
                ST_MR_GAP:     if (gap_over) state_q <= ST_LOAD_EMR;
                ST_LOAD_EMR:   state_q <= ST_EMR_GAP;
                ST_EMR_GAP:    if (gap_over) state_q <= ST_READY;
                ST_READY:      state_q <= ST_READY;
                ST_BAD_CFG:    state_q <= ST_BAD_CFG;
                default:       state_q <= ST_PWR_WAIT;
            endcase
        end
    end

    // Outputs decoded from state
    always_comb begin
        cmd       = CMD_NOP;
        mem_ba    = '0;
        mem_addr  = '0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        init_done = 1'b0;
        cfg_err   = 1'b0;
        unique case (state_q)
            ST_PRECHG: begin
                cmd          = CMD_PALL;
                mem_addr[10] = 1'b1;
                tmr_load     = 1'b1;
                tmr_val      = PRE_LD;
            end
            ST_REFR1, ST_REFR2: begin
                cmd      = CMD_AREF;
                tmr_load = 1'b1;
                tmr_val  = RFC_LD;
            end
            ST_LOAD_MR: begin
                cmd      = CMD_LMR;
                mem_ba   = BANK_MR;
                mem_addr = mode_word;
                tmr_load = 1'b1;
                tmr_val  = MRD_LD;
            end
            ST_LOAD_EMR: begin
                cmd      = CMD_LMR;
                mem_ba   = BANK_EMR;
                mem_addr = ADDR_W'(EMR_WORD);
                tmr_load = 1'b1;
                tmr_val  = MRD_LD;
            end
            ST_READY:   init_done = 1'b1;
            ST_BAD_CFG: cfg_err   = 1'b1;
            default: ;
        endcase
    end

    assign mem_cke = 1'b1;
    assign mem_dqm = '1;
    assign {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = cmd;

endmodule

// File: rtl/sdram_boot_chk.sv
module sdram_boot_chk #(
    parameter int ADDR_W = 13,
    parameter int DQM_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_cke,
    input logic [DQM_W-1:0]  mem_dqm,
    input logic              mem_cs_n,
    input logic              mem_ras_n,
    input logic              mem_cas_n,
    input logic              mem_we_n,
    input logic [1:0]        mem_ba,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              init_done,
    input logic              cfg_err
);

    logic [3:0] cmd;
    assign cmd = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};

    // R1
    cke_dqm_high_chk: assert property (@(posedge clk)
        mem_cke && (&mem_dqm));

    // R2
    cmd_then_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != 4'b0111) |=> (cmd == 4'b0111));

    // R5
    mr_word_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0000 && mem_ba == 2'b00) |->
        ((mem_addr[6:4] == 3'b010 || mem_addr[6:4] == 3'b011) &&
         mem_addr[8:7] == 2'b00 && !(mem_addr[2:0] == 3'b111 && mem_addr[3])));

    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    // R8
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (cmd == 4'b0111));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> (cfg_err && !init_done && cmd == 4'b0111));

endmodule

bind sdram_boot_seq sdram_boot_chk #(
    .ADDR_W (ADDR_W),
    .DQM_W  (DQM_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_cke   (mem_cke),
    .mem_dqm   (mem_dqm),
    .mem_cs_n  (mem_cs_n),
    .mem_ras_n (mem_ras_n),
    .mem_cas_n (mem_cas_n),
    .mem_we_n  (mem_we_n),
    .mem_ba    (mem_ba),
    .mem_addr  (mem_addr),
    .init_done (init_done),
    .cfg_err   (cfg_err)
);

// File: tb/sdram_boot_seq_test.sv
module sdram_boot_seq_test;

    localparam int          TP  = 12;
    localparam int          RP  = 3;
    localparam int          RFC = 5;
    localparam int          MRD = 2;
    localparam int          AW  = 13;
    localparam int          DW  = 2;
    localparam logic [12:0] EMR = 13'h0021;

    localparam int C_PRE = TP;
    localparam int C_R1  = C_PRE + 1 + RP;
    localparam int C_R2  = C_R1 + 1 + RFC;
    localparam int C_MR  = C_R2 + 1 + RFC;
    localparam int C_EMR = C_MR + 1 + MRD;
    localparam int C_RDY = C_EMR + 1 + MRD;
    localparam int RUN   = C_RDY + 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    cfg_blen = 3'b0;
    logic          cfg_btype = 1'b0;
    logic [2:0]    cfg_cas = 3'b010;
    logic          cfg_wsingle = 1'b0;
    logic          mem_cke;
    logic [DW-1:0] mem_dqm;
    logic          mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n;
    logic [1:0]    mem_ba;
    logic [AW-1:0] mem_addr;
    logic          init_done, cfg_err;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    sdram_boot_seq #(
        .PWR_CYC (TP), .PRE_CYC (RP), .RFC_CYC (RFC), .MRD_CYC (MRD),
        .ADDR_W (AW), .DQM_W (DW), .EMR_WORD (EMR)
    ) uut (
        .clk (clk), .rst_n (rst_n),
        .cfg_blen (cfg_blen), .cfg_btype (cfg_btype),
        .cfg_cas (cfg_cas), .cfg_wsingle (cfg_wsingle),
        .mem_cke (mem_cke), .mem_dqm (mem_dqm),
        .mem_cs_n (mem_cs_n), .mem_ras_n (mem_ras_n),
        .mem_cas_n (mem_cas_n), .mem_we_n (mem_we_n),
        .mem_ba (mem_ba), .mem_addr (mem_addr),
        .init_done (init_done), .cfg_err (cfg_err)
    );

    function automatic logic cfg_ok(logic [2:0] bl, logic bt, logic [2:0] cl);
        logic b;
        b = (bl <= 3'd3) || (bl == 3'd7 && !bt);
        return b && (cl == 3'd2 || cl == 3'd3);
    endfunction

    function automatic logic [AW-1:0] mr_word(logic [2:0] bl, logic bt, logic [2:0] cl, logic ws);
        logic [AW-1:0] w;
        w = '0;
        w[2:0] = bl; w[3] = bt; w[6:4] = cl; w[9] = ws;
        return w;
    endfunction

    // packed view: {cke, dqm_all, cmd[3:0], ba[1:0], addr, done, err}
    function automatic logic [AW+9:0] observe();
        return {mem_cke, &mem_dqm, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n,
                mem_ba, mem_addr, init_done, cfg_err};
    endfunction

    function automatic logic [AW+9:0] pack(logic [3:0] c, logic [1:0] b, logic [AW-1:0] a,
                                           logic d, logic e);
        return {1'b1, 1'b1, c, b, a, d, e};
    endfunction

    task automatic check(string tag, logic [AW+9:0] got, logic [AW+9:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic run_trial(logic [2:0] bl, logic bt, logic [2:0] cl, logic ws);
        logic ok;
        logic [AW+9:0] e;
        string tag;
        ok = cfg_ok(bl, bt, cl);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_blen = bl; cfg_btype = bt; cfg_cas = cl; cfg_wsingle = ws;
        @(negedge clk);
        @(negedge clk);
        // R1 R2 reset state
        check("R1/R2 reset", observe(), pack(4'b0111, 2'b00, '0, 1'b0, 1'b0));
        rst_n = 1'b1;
        for (int k = 0; k < RUN; k++) begin
            if (k > 0) @(negedge clk);
            e = pack(4'b0111, 2'b00, '0, 1'b0, 1'b0);
            tag = "R2 nop";
            if (k == C_PRE) begin
                e = pack(4'b0010, 2'b00, AW'(1 << 10), 1'b0, 1'b0); tag = "R3 precharge";
            end else if (k == C_R1 || k == C_R2) begin
                e = pack(4'b0001, 2'b00, '0, 1'b0, 1'b0); tag = "R4 refresh";
            end else if (k > C_PRE && k < C_R1) begin
                tag = "R3 gap";
            end else if (k > C_R1 && k < C_MR) begin
                tag = "R4 gap";
            end else if (k >= C_MR && !ok) begin
                e = pack(4'b0111, 2'b00, '0, 1'b0, 1'b1); tag = "R9 bad config";
            end else if (k == C_MR) begin
                e = pack(4'b0000, 2'b00, mr_word(bl, bt, cl, ws), 1'b0, 1'b0); tag = "R5/R6 mode load";
            end else if (k > C_MR && k < C_EMR) begin
                tag = "R5 gap";
            end else if (k == C_EMR) begin
                e = pack(4'b0000, 2'b10, AW'(EMR), 1'b0, 1'b0); tag = "R7 ext load";
            end else if (k > C_EMR && k < C_RDY) begin
                tag = "R7 gap";
            end else if (k >= C_RDY) begin
                e = pack(4'b0111, 2'b00, '0, 1'b1, 1'b0); tag = "R8 done";
            end
            check(tag, observe(), e);
        end
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5D3A1);
        // directed corners (R6)
        run_trial(3'b111, 1'b0, 3'b010, 1'b0); // full page sequential: legal
        run_trial(3'b111, 1'b1, 3'b011, 1'b1); // full page interleaved: illegal
        run_trial(3'b011, 1'b1, 3'b011, 1'b1); // burst 8 interleaved CL3 single
        run_trial(3'b000, 1'b0, 3'b001, 1'b0); // CL code 1: illegal
        run_trial(3'b100, 1'b0, 3'b010, 1'b0); // BL code 4: illegal
        run_trial(3'b010, 1'b1, 3'b100, 1'b0); // CL code 4: illegal
        for (int t = 0; t < 30; t++) begin
            logic [2:0] bl, cl;
            logic bt, ws;
            bl = 3'($urandom % 8);
            bt = 1'($urandom % 2);
            cl = (($urandom % 4) != 0) ? 3'(2 + ($urandom % 2)) : 3'($urandom % 8);
            ws = 1'($urandom % 2);
            run_trial(bl, bt, cl, ws);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule